// File: doc/BRIEF.md
# Register Hazard Stall Calculator

This block works out how many stall cycles each instruction of a short in-order pipeline costs through register dependencies. The issue logic hands it one instruction at a time: a class code, a source register, a destination-input register, a destination-output register (each with its own valid bit) and a block-transfer limit. The block compares these against a three-deep history of which registers recent instructions modified and which registers a block load filled. When the instruction is done it pulses `done` with that instruction's total stall count.

Every penalty cycle is carried out as a real clock cycle. In that cycle the histories shift by one generation and an empty generation is inserted. Hazards therefore age while the stalls are paid, exactly as they would in the pipeline. Six counters, one per cause, add up all stall cycles since reset, so a profiler can read where the cycles went.

Top module: `hz_stall_calc`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all history generations and all six cause counters. After reset `in_ready` is 1 and `done` is 0.
- R2: An instruction is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until the result is out. `done` is a one-cycle pulse, and `stall_total` is valid while it is high. Class codes are: 0 plain exec, 1 address use, 2 memory read, 3 memory write, 4 multiply, 5 jump to register, 6 block store, 7 block load.
- R3: Register numbers 0..31 index a 32-bit mask, and special register k is given as 16+k. A destination write to 16 or 20 leaves no mark. Bit 16 is the jump marker, bit 20 the memory-write marker and bit 23 the multiply-overflow register. A memory-write instruction sets bit 20 in its generation.
- R4: If the source register, and then the destination-input register, was filled by a block load, the cost is 3 stalls when that load was 1 instruction back, 2 when 2 back and 1 when 3 back. Only the nearest load counts. The source is checked first, and its stalls age the history before the destination-input check.
- R5: An address-use instruction whose source was modified by the immediately preceding instruction costs 1 stall.
- R6: A memory read costs 2 stalls when the memory-write marker is set in either of the two newest generations.
- R7: A jump to register costs 2 stalls if its source was modified 1 back, and 1 stall if only 2 back. It sets the jump marker.
- R8: A block store with limit L costs 2 stalls if any of registers 0..L was modified 1 back, and 1 stall if only 2 back. A match 3 back costs nothing.
- R9: A block load with limit L marks registers 0..L both as modified and as block-load destinations.
- R10: A multiply costs 1 stall if its source or destination-input was modified 1 back. It marks the overflow register (bit 23) and its destination as modified.
- R11: Each stall cycle shifts both histories down one generation and inserts an empty one, so the total per instruction never exceeds 8.
- R12: Cause counters accumulate stall cycles by cause. The index order is: 0 block-load destination, 1 address use, 2 read after write, 3 multiply, 4 jump source, 5 block-store source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block can accept an instruction |
| in_cls | input | 3 | Instruction class code |
| src_vld | input | 1 | Source register present |
| src_idx | input | 5 | Source register number |
| din_vld | input | 1 | Destination-input register present |
| din_idx | input | 5 | Destination-input register number |
| dout_vld | input | 1 | Destination-output register present |
| dout_idx | input | 5 | Destination-output register number |
| blk_lim | input | 4 | Highest register of a block transfer |
| done | output | 1 | Result pulse |
| stall_total | output | 4 | Stall cycles of the finished instruction |
| cause_cnt | output | 6x16 | Packed per-cause stall counters |

## Verification
A wrong history shows up at the ports as a wrong `stall_total` on the first later instruction that reads the damaged generation. That can be up to three instructions after the fault, and it appears on that instruction's `done` pulse. Faulty aging during stalls shows up within the same instruction whenever both a source and a destination-input check apply, or on the next instruction that looks back two or three generations. A miscounted cause is held in the counters, so it is still visible at any later read.

// File: rtl/hz_pkg.sv
package hz_pkg;
   typedef enum logic [2:0] {
      CL_EXEC  = 3'd0,
      CL_ADDR  = 3'd1,
      CL_MRD   = 3'd2,
      CL_MWR   = 3'd3,
      CL_MUL   = 3'd4,
      CL_JREG  = 3'd5,
      CL_BLKST = 3'd6,
      CL_BLKLD = 3'd7
   } hz_cls_e;

   typedef enum logic [1:0] {
      PH_CLASS = 2'd0,
      PH_SRC   = 2'd1,
      PH_DIN   = 2'd2
   } hz_phase_e;

   typedef enum logic [1:0] {
      S_IDLE   = 2'd0,
      S_EVAL   = 2'd1,
      S_DRAIN  = 2'd2,
      S_COMMIT = 2'd3
   } hz_state_e;

   localparam int NCAUSE    = 6;
   localparam int CZ_BLKDST = 0;
   localparam int CZ_ADDR   = 1;
   localparam int CZ_RAW    = 2;
   localparam int CZ_MUL    = 3;
   localparam int CZ_JUMP   = 4;
   localparam int CZ_BLKSRC = 5;

   localparam int SPEC_BASE = 16;
   localparam int BIT_JUMP  = 16;
   localparam int BIT_MWR   = 20;
   localparam int BIT_MOVF  = 23;
endpackage

// File: rtl/hz_history.sv
module hz_history #(
   parameter int MASK_W = 32,
   parameter int DEPTH  = 3
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         stall_shift,
   input  logic                         commit_shift,
   input  logic [MASK_W-1:0]            new_modf,
   input  logic [MASK_W-1:0]            new_mdst,
   output logic [DEPTH-1:0][MASK_W-1:0] modf_h,
   output logic [DEPTH-1:0][MASK_W-1:0] mdst_h
);
   logic any_shift;
   assign any_shift = stall_shift | commit_shift;

   for (genvar g = 0; g < DEPTH; g++) begin : g_gen
      if (g == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst) begin
               modf_h[0] <= '0;
               mdst_h[0] <= '0;
            end else if (commit_shift) begin
               modf_h[0] <= new_modf;
               mdst_h[0] <= new_mdst;
            end else if (stall_shift) begin
               modf_h[0] <= '0;
               mdst_h[0] <= '0;
            end
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (rst) begin
               modf_h[g] <= '0;
               mdst_h[g] <= '0;
            end else if (any_shift) begin
               modf_h[g] <= modf_h[g-1];
               mdst_h[g] <= mdst_h[g-1];
            end
         end
      end
   end
endmodule

// File: rtl/hz_penalty.sv
module hz_penalty
   import hz_pkg::*;
#(
   parameter int MASK_W = 32,
   parameter int REG_W  = 5,
   parameter int LIM_W  = 4,
   parameter int DEPTH  = 3,
   parameter int NEED_W = 2,
   parameter int SEL_W  = 3
) (
   input  hz_phase_e                    phase,
   input  hz_cls_e                      cls,
   input  logic                         src_vld,
   input  logic [REG_W-1:0]             src_idx,
   input  logic                         din_vld,
   input  logic [REG_W-1:0]             din_idx,
   input  logic [LIM_W-1:0]             lim,
   input  logic [DEPTH-1:0][MASK_W-1:0] modf_h,
   input  logic [DEPTH-1:0][MASK_W-1:0] mdst_h,
   output logic [NEED_W-1:0]            need,
   output logic [SEL_W-1:0]             cause
);
   logic [MASK_W-1:0] blk_mask;
   logic [MASK_W-1:0] src_bit;
   logic [MASK_W-1:0] din_bit;
   logic [NEED_W-1:0] need_class;
   logic [SEL_W-1:0]  cause_class;
   logic [NEED_W-1:0] need_src;
   logic [NEED_W-1:0] need_din;

   always_comb begin
      for (int i = 0; i < MASK_W; i++) begin
         blk_mask[i] = (i <= int'(lim));
      end
   end

   assign src_bit = src_vld ? (MASK_W'(1) << src_idx) : '0;
   assign din_bit = din_vld ? (MASK_W'(1) << din_idx) : '0;

   always_comb begin
      need_class  = '0;
      cause_class = SEL_W'(CZ_ADDR);
      unique case (cls)
         CL_ADDR: begin
            cause_class = SEL_W'(CZ_ADDR);
            if ((src_bit & modf_h[0]) != '0) need_class = NEED_W'(1);
         end
         CL_MRD: begin
            cause_class = SEL_W'(CZ_RAW);
            if (modf_h[0][BIT_MWR] || modf_h[1][BIT_MWR]) need_class = NEED_W'(2);
         end
         CL_MUL: begin
            cause_class = SEL_W'(CZ_MUL);
            if (((src_bit | din_bit) & modf_h[0]) != '0) need_class = NEED_W'(1);
         end
         CL_JREG: begin
            cause_class = SEL_W'(CZ_JUMP);
            if ((src_bit & modf_h[0]) != '0)      need_class = NEED_W'(2);
            else if ((src_bit & modf_h[1]) != '0) need_class = NEED_W'(1);
         end
         CL_BLKST: begin
            cause_class = SEL_W'(CZ_BLKSRC);
            if ((blk_mask & modf_h[0]) != '0)      need_class = NEED_W'(2);
            else if ((blk_mask & modf_h[1]) != '0) need_class = NEED_W'(1);
         end
         default: need_class = '0;
      endcase
   end

   // nearest generation wins: scan from oldest to newest
   always_comb begin
      need_src = '0;
      need_din = '0;
      for (int g = DEPTH - 1; g >= 0; g--) begin
         if ((src_bit & mdst_h[g]) != '0) need_src = NEED_W'(DEPTH - g);
         if ((din_bit & mdst_h[g]) != '0) need_din = NEED_W'(DEPTH - g);
      end
   end

   always_comb begin
      unique case (phase)
         PH_CLASS: begin need = need_class; cause = cause_class;        end
         PH_SRC:   begin need = need_src;   cause = SEL_W'(CZ_BLKDST); end
         PH_DIN:   begin need = need_din;   cause = SEL_W'(CZ_BLKDST); end
         default:  begin need = '0;         cause = SEL_W'(CZ_BLKDST); end
      endcase
   end
endmodule

// File: rtl/hz_counters.sv
module hz_counters #(
   parameter int NC     = 6,
   parameter int CNT_W  = 16,
   parameter int NEED_W = 2,
   parameter int SEL_W  = 3
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     inc_en,
   input  logic [SEL_W-1:0]         inc_sel,
   input  logic [NEED_W-1:0]        inc_amt,
   output logic [NC-1:0][CNT_W-1:0] cnt
);
   for (genvar c = 0; c < NC; c++) begin : g_cnt
      always_ff @(posedge clk) begin
         if (rst)
            cnt[c] <= '0;
         else if (inc_en && (inc_sel == SEL_W'(c)))
            cnt[c] <= cnt[c] + CNT_W'(inc_amt);
      end
   end
endmodule

// File: rtl/hz_stall_calc.sv
module hz_stall_calc
   import hz_pkg::*;
#(
   parameter int MASK_W = 32,
   parameter int LIM_W  = 4,
   parameter int DEPTH  = 3,
   parameter int CNT_W  = 16,
   parameter int TOT_W  = 4
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic                               in_valid,
   output logic                               in_ready,
   input  logic [2:0]                         in_cls,
   input  logic                               src_vld,
   input  logic [$clog2(MASK_W)-1:0]          src_idx,
   input  logic                               din_vld,
   input  logic [$clog2(MASK_W)-1:0]          din_idx,
   input  logic                               dout_vld,
   input  logic [$clog2(MASK_W)-1:0]          dout_idx,
   input  logic [LIM_W-1:0]                   blk_lim,
   output logic                               done,
   output logic [TOT_W-1:0]                   stall_total,
   output logic [NCAUSE-1:0][CNT_W-1:0]       cause_cnt
);
   localparam int REG_W     = $clog2(MASK_W);
   localparam int NEED_W    = $clog2(DEPTH + 1);
   localparam int SEL_W     = $clog2(NCAUSE);
   localparam int MAX_STALL = 2 + 2 * DEPTH;

   if (MASK_W < BIT_MOVF + 1) begin : g_bad_mask
      $error("MASK_W must cover the marker bits");
   end
   if ((1 << LIM_W) > SPEC_BASE) begin : g_bad_lim
      $error("LIM_W must address general registers only");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if ((1 << TOT_W) <= MAX_STALL) begin : g_bad_tot
      $error("TOT_W too narrow for the largest stall count");
   end

   hz_state_e         state;
   hz_phase_e         phase;
   hz_cls_e           cls_q;
   logic              src_vld_q, din_vld_q, dout_vld_q;
   logic [REG_W-1:0]  src_q, din_q, dout_q;
   logic [LIM_W-1:0]  lim_q;
   logic [NEED_W-1:0] left;
   logic [TOT_W-1:0]  total;

   logic [NEED_W-1:0] need;
   logic [SEL_W-1:0]  cause;
   logic              stall_shift, commit_shift;
   logic [MASK_W-1:0] new_modf, new_mdst, blk_mask, dout_mark;
   logic [DEPTH-1:0][MASK_W-1:0] modf_h, mdst_h;

   assign in_ready     = (state == S_IDLE);
   assign stall_shift  = (state == S_DRAIN) && (left != '0);
   assign commit_shift = (state == S_COMMIT);

   always_comb begin
      for (int i = 0; i < MASK_W; i++) begin
         blk_mask[i] = (i <= int'(lim_q));
      end
   end

   // writes to the constant-zero positions leave no mark
   assign dout_mark = (dout_vld_q && (int'(dout_q) != BIT_JUMP) && (int'(dout_q) != BIT_MWR))
                      ? (MASK_W'(1) << dout_q) : '0;

   always_comb begin
      new_modf = dout_mark;
      new_mdst = '0;
      unique case (cls_q)
         CL_MWR:   new_modf[BIT_MWR]  = 1'b1;
         CL_JREG:  new_modf[BIT_JUMP] = 1'b1;
         CL_MUL:   new_modf[BIT_MOVF] = 1'b1;
         CL_BLKLD: begin
            new_modf = dout_mark | blk_mask;
            new_mdst = blk_mask;
         end
         default: new_mdst = '0;
      endcase
   end

   hz_history #(.MASK_W(MASK_W), .DEPTH(DEPTH)) u_hist (
      .clk          (clk),
      .rst          (rst),
      .stall_shift  (stall_shift),
      .commit_shift (commit_shift),
      .new_modf     (new_modf),
      .new_mdst     (new_mdst),
      .modf_h       (modf_h),
      .mdst_h       (mdst_h)
   );

   hz_penalty #(
      .MASK_W (MASK_W), .REG_W (REG_W), .LIM_W (LIM_W),
      .DEPTH  (DEPTH),  .NEED_W(NEED_W), .SEL_W (SEL_W)
   ) u_pen (
      .phase   (phase),
      .cls     (cls_q),
      .src_vld (src_vld_q),
      .src_idx (src_q),
      .din_vld (din_vld_q),
      .din_idx (din_q),
      .lim     (lim_q),
      .modf_h  (modf_h),
      .mdst_h  (mdst_h),
      .need    (need),
      .cause   (cause)
   );

   hz_counters #(.NC(NCAUSE), .CNT_W(CNT_W), .NEED_W(NEED_W), .SEL_W(SEL_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .inc_en  ((state == S_EVAL) && (need != '0)),
      .inc_sel (cause),
      .inc_amt (need),
      .cnt     (cause_cnt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state       <= S_IDLE;
         phase       <= PH_CLASS;
         cls_q       <= CL_EXEC;
         src_vld_q   <= 1'b0;
         din_vld_q   <= 1'b0;
         dout_vld_q  <= 1'b0;
         src_q       <= '0;
         din_q       <= '0;
         dout_q      <= '0;
         lim_q       <= '0;
         left        <= '0;
         total       <= '0;
         done        <= 1'b0;
         stall_total <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            S_IDLE: begin
               if (in_valid) begin
                  cls_q      <= hz_cls_e'(in_cls);
                  src_vld_q  <= src_vld;
                  din_vld_q  <= din_vld;
                  dout_vld_q <= dout_vld;
                  src_q      <= src_idx;
                  din_q      <= din_idx;
                  dout_q     <= dout_idx;
                  lim_q      <= blk_lim;
                  phase      <= PH_CLASS;
                  total      <= '0;
                  state      <= S_EVAL;
               end
            end
            S_EVAL: begin
               left  <= need;
               total <= total + TOT_W'(need);
               state <= S_DRAIN;
            end
            S_DRAIN: begin
               if (left != '0) begin
                  left <= left - NEED_W'(1);
               end else if (phase == PH_DIN) begin
                  state <= S_COMMIT;
               end else begin
                  phase <= hz_phase_e'(phase + 2'd1);
                  state <= S_EVAL;
               end
            end
            S_COMMIT: begin
               done        <= 1'b1;
               stall_total <= total;
               state       <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hz_stall_calc_chk.sv
module hz_stall_calc_chk #(
   parameter int NC    = 6,
   parameter int CNT_W = 16,
   parameter int TOT_W = 4,
   parameter int MAXS  = 8
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     in_valid,
   input logic                     in_ready,
   input logic                     done,
   input logic [TOT_W-1:0]         stall_total,
   input logic [NC-1:0][CNT_W-1:0] cause_cnt
);
   assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (in_ready && !done && (cause_cnt == '0)));

   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> !in_ready);

   assert_stall_bound_R11: assert property (@(posedge clk) disable iff (rst)
      done |-> (int'(stall_total) <= MAXS));

   assert_counts_grow_R12: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (cause_cnt >= $past(cause_cnt)));
endmodule

bind hz_stall_calc hz_stall_calc_chk #(
   .NC(hz_pkg::NCAUSE), .CNT_W(CNT_W), .TOT_W(TOT_W), .MAXS(2 + 2 * DEPTH)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .done        (done),
   .stall_total (stall_total),
   .cause_cnt   (cause_cnt)
);

// File: tb/hz_stall_calc_bench.sv
module hz_stall_calc_bench;
   localparam int CNT_W = 16;
   localparam int NVEC  = 32;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst = 1'b1;
   logic in_valid = 1'b0, in_ready;
   logic [2:0] in_cls = '0;
   logic src_vld = 1'b0, din_vld = 1'b0, dout_vld = 1'b0;
   logic [4:0] src_idx = '0, din_idx = '0, dout_idx = '0;
   logic [3:0] blk_lim = '0;
   logic done;
   logic [3:0] stall_total;
   logic [5:0][CNT_W-1:0] cause_cnt;

   hz_stall_calc u_hz_stall_calc (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_cls(in_cls), .src_vld(src_vld), .src_idx(src_idx),
      .din_vld(din_vld), .din_idx(din_idx), .dout_vld(dout_vld),
      .dout_idx(dout_idx), .blk_lim(blk_lim), .done(done),
      .stall_total(stall_total), .cause_cnt(cause_cnt)
   );

   int n_chk = 0;
   int n_err = 0;
   int cyc   = 0;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_err++;
         $display("FAIL R2 watchdog: actual=%0d cycles expected<=20000", cyc);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // packing: cls[31:29] sv[28] s[27:23] dv[22] d[21:17] ov[16] o[15:11] lim[10:7] exp[6:3]
   function automatic logic [31:0] v(int c, int sv, int s, int dv, int d,
                                      int ov, int o, int l, int e);
      return {3'(c), 1'(sv), 5'(s), 1'(dv), 5'(d), 1'(ov), 5'(o), 4'(l), 4'(e), 3'b0};
   endfunction

   function automatic string req_of(int c);
      case (c)
         0: return "R4";
         1: return "R5";
         2: return "R6";
         3: return "R3";
         4: return "R10";
         5: return "R7";
         6: return "R8";
         default: return "R9";
      endcase
   endfunction

   localparam logic [31:0] VEC [NVEC] = '{
      v(7,1,14,0,0,0,0,3,0),  // R9 block load r0..r3
      v(0,1,2,0,0,1,5,0,3),   // R4 source filled 1 back
      v(1,1,5,0,0,0,0,0,1),   // R5 address modified 1 back
      v(3,1,1,0,0,0,0,0,0),   // R3 memory write marker
      v(0,1,3,0,0,1,6,0,0),
      v(2,1,7,0,0,0,0,0,2),   // R6 write 2 back
      v(0,0,0,0,0,1,9,0,0),
      v(5,1,9,0,0,0,0,0,2),   // R7 1 back
      v(0,0,0,0,0,1,10,0,0),
      v(0,0,0,0,0,1,2,0,0),
      v(5,1,10,0,0,0,0,0,1),  // R7 2 back
      v(6,1,14,0,0,0,0,2,0),  // R8 r2 only 3 back: free
      v(0,0,0,0,0,1,1,0,0),
      v(6,1,14,0,0,0,0,1,2),  // R8 1 back
      v(0,0,0,0,0,1,4,0,0),
      v(0,0,0,0,0,1,8,0,0),
      v(6,1,14,0,0,0,0,4,1),  // R8 2 back
      v(4,1,8,1,3,1,3,0,0),   // R10 no hazard
      v(4,1,3,1,12,1,12,0,1), // R10 operand 1 back
      v(0,1,0,0,0,1,16,0,0),  // R3 write to 16 unmarked
      v(5,1,16,0,0,0,0,0,0),
      v(0,0,0,0,0,1,20,0,0),  // R3 write to 20 unmarked
      v(2,1,0,0,0,0,0,0,0),
      v(7,1,14,0,0,0,0,1,0),
      v(0,0,0,0,0,1,9,0,0),
      v(0,0,0,1,1,1,1,0,2),   // R4 dest-input 2 back
      v(7,1,14,0,0,0,0,0,0),
      v(0,0,0,0,0,1,5,0,0),
      v(0,0,0,0,0,1,6,0,0),
      v(0,1,0,0,0,1,7,0,1),   // R4 3 back
      v(7,1,14,0,0,0,0,2,0),
      v(0,1,2,1,2,1,2,0,3)    // R11 source stalls age the dest-input hazard
   };

   task automatic issue(input logic [31:0] w, input bit chk_busy, output int got);
      @(negedge clk);
      in_cls   = w[31:29];
      src_vld  = w[28];  src_idx  = w[27:23];
      din_vld  = w[22];  din_idx  = w[21:17];
      dout_vld = w[16];  dout_idx = w[15:11];
      blk_lim  = w[10:7];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      if (chk_busy) chk("R2", "in_ready after accept", int'(in_ready), 0);
      got = -1;
      for (int k = 0; k < 40; k++) begin
         if (done) begin
            got = int'(stall_total);
            break;
         end
         @(negedge clk);
      end
      if (chk_busy) begin
         @(negedge clk);
         chk("R2", "done width", int'(done), 0);
      end
   endtask

   initial begin
      int got;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", "in_ready after reset", int'(in_ready), 1);
      chk("R1", "done after reset", int'(done), 0);
      chk("R1", "counters after reset", int'(cause_cnt != '0), 0);

      for (int i = 0; i < NVEC; i++) begin
         issue(VEC[i], (i == 0), got);
         chk(req_of(int'(VEC[i][31:29])), $sformatf("vector %0d stalls", i), got,
             int'(VEC[i][6:3]));
      end

      chk("R12", "block-load destination count", int'(cause_cnt[0]), 9);
      chk("R12", "address count", int'(cause_cnt[1]), 1);
      chk("R12", "read-after-write count", int'(cause_cnt[2]), 2);
      chk("R12", "multiply count", int'(cause_cnt[3]), 1);
      chk("R12", "jump count", int'(cause_cnt[4]), 3);
      chk("R12", "block-store count", int'(cause_cnt[5]), 3);

      // R1: reset clears a pending block-load hazard and the counters
      issue(v(7,1,14,0,0,0,0,3,0), 1'b0, got);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", "counters cleared", int'(cause_cnt != '0), 0);
      issue(v(0,1,0,0,0,0,0,0,0), 1'b0, got);
      chk("R1", "history cleared", got, 0);

      // R8 with L=15 covering r15 modified 1 back
      issue(v(0,0,0,0,0,1,15,0,0), 1'b0, got);
      issue(v(6,1,14,0,0,0,0,15,2), 1'b0, got);
      chk("R8", "limit 15 reaches r15", got, 2);
      chk("R12", "block-store count after reset", int'(cause_cnt[5]), 2);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule